// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block records a window of probe samples into on-chip memory once a run-time trigger has fired. Software or surrounding logic loads the trigger stages, the capture qualifier and a control word through a small register-write port, then pulses `arm`. The core stays silent until its trigger fires. The trigger is either a sequence of one to four masked pattern matches, taken strictly in order, or the external cross-trigger input. After the trigger, each sample on which the clock enable is high and the qualifier matches is written to the buffer.

The buffer is split evenly into one to four windows. Each window needs its own trigger, and the windows are filled one after another at consecutive addresses. When the last window is full the core raises `done` and goes idle. The contents can then be unloaded through the read port, address 0 first, in capture order. A one-cycle cross-trigger output pulse lets several such cores trigger one another.

Top module: `trig_capture_buf`

## Requirements
- R1: After `arm` the core holds `ready`=1, clears `done`, and stores no sample until the trigger fires; the sample on the trigger cycle is the first candidate for storage.
- R2: A stage k matches when ((probe XOR value_k) AND mask_k) is zero; value_k is written at address k, mask_k at address 4+k (k=0..3); mask bits at 0 are don't-care.
- R3: Control word at address 10: bits [1:0] hold the stage count minus one; stages must match in order, each on a later sample than the previous one, and the trigger fires on the match of the last active stage; a non-matching sample leaves the current stage unchanged.
- R4: The stage sequence restarts at stage 0 on every `arm` and at the start of every window.
- R5: The capture qualifier (value at address 8, mask at address 9, same match rule as R2) is checked on every sample; after the trigger a sample, including the trigger sample, is stored only when it matches.
- R6: Control bits [4:3] hold the window count minus one; each window holds floor(16/N) samples for N windows, needs its own trigger, and windows occupy consecutive addresses from 0.
- R7: When control bit 2 is set, the trigger fires on a waiting sample with `xtrig_in`=1 and the probe stages are ignored; `xtrig_out` pulses high for one cycle in the cycle after every trigger.
- R8: On a cycle with `clk_en`=0 the core neither stores, nor advances a stage, nor triggers.
- R9: After reset `ready`=0 and `done`=0; when the last window is full `done` rises, `ready` falls, and both keep their values until the next `arm`.
- R10: With `rd_en`=1 and `ready`=0, `rd_data` shows the sample at `rd_addr` on the next cycle; while `ready`=1 read requests are ignored and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| clk_en | input | 1 | Sample enable |
| probe | input | PW | Probe data bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | PW | Configuration write data |
| arm | input | 1 | Start a new capture run |
| xtrig_in | input | 1 | Cross-trigger input |
| xtrig_out | output | 1 | One-cycle pulse after a trigger |
| ready | output | 1 | Armed, waiting or capturing |
| done | output | 1 | All windows full |
| rd_en | input | 1 | Read request |
| rd_addr | input | IW | Read address |
| rd_data | output | PW | Read data, one cycle after request |

## Verification
On every cycle the assertions check these properties: the stage index moves by at most one step and returns to stage 0 on a restart; a waiting core holds an empty window; a disabled sample leaves the state and fill count untouched; every trigger is followed by an output pulse; the buffer pointer never passes the depth; `done` excludes `ready`; and read data holds still while a capture is in progress. Only the bench scenarios show what was captured and where it landed. These cover out-of-order stage matches, the effect of masks, the qualifier dropping a trigger sample, the split into three windows with its floor division, re-arming in the middle of a sequence and the external trigger source. The bench compares the buffer contents read back through the port with lists it derives from the requirements.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } cap_state_t;

  // Samples per window: the depth divided evenly, remainder unused.
  function automatic int unsigned window_len(int unsigned depth, int unsigned nwin);
    return depth / nwin;
  endfunction

endpackage

// File: rtl/tcb_cfg.sv
module tcb_cfg #(
  parameter int PW     = 8,
  parameter int STAGES = 4,
  parameter int AW     = 4,
  parameter int SW     = 2,
  parameter int WSW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [PW-1:0]              wdata,
  output logic [STAGES-1:0][PW-1:0]  stage_val,
  output logic [STAGES-1:0][PW-1:0]  stage_msk,
  output logic [PW-1:0]              qual_val,
  output logic [PW-1:0]              qual_msk,
  output logic [SW-1:0]              stage_last,
  output logic                       use_xin,
  output logic [WSW-1:0]             win_last
);
  localparam int A_QV  = 2 * STAGES;
  localparam int A_QM  = A_QV + 1;
  localparam int A_CTL = A_QV + 2;
  localparam int CW    = SW + 1 + WSW;

  logic [CW-1:0] ctrl_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_val[k] <= '0;
        stage_msk[k] <= '0;
      end else if (we) begin
        if (addr == AW'(k))          stage_val[k] <= wdata;
        if (addr == AW'(STAGES + k)) stage_msk[k] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_val <= '0;
      qual_msk <= '0;
      ctrl_q   <= '0;
    end else if (we) begin
      if (addr == AW'(A_QV))  qual_val <= wdata;
      if (addr == AW'(A_QM))  qual_msk <= wdata;
      if (addr == AW'(A_CTL)) ctrl_q   <= wdata[CW-1:0];
    end
  end

  assign stage_last = ctrl_q[SW-1:0];
  assign use_xin    = ctrl_q[SW];
  assign win_last   = ctrl_q[SW+WSW:SW+1];

endmodule

// File: rtl/tcb_trig.sv
module tcb_trig #(
  parameter int PW     = 8,
  parameter int STAGES = 4,
  parameter int SW     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clk_en,
  input  logic [PW-1:0]              probe,
  input  logic                       seek,
  input  logic                       restart,
  input  logic [STAGES-1:0][PW-1:0]  stage_val,
  input  logic [STAGES-1:0][PW-1:0]  stage_msk,
  input  logic [SW-1:0]              stage_last,
  input  logic                       use_xin,
  input  logic                       xtrig_in,
  output logic                       trig_fire
);
  logic [STAGES-1:0] hit;
  logic [SW-1:0]     stage_q;
  logic              cur_hit;
  logic              at_last;
  logic              advance;

  function automatic logic masked_eq(logic [PW-1:0] d, logic [PW-1:0] v, logic [PW-1:0] m);
    return ~|((d ^ v) & m);
  endfunction

  for (genvar k = 0; k < STAGES; k++) begin : g_match
    assign hit[k] = masked_eq(probe, stage_val[k], stage_msk[k]);
  end

  assign cur_hit   = hit[stage_q];
  assign at_last   = (stage_q == stage_last);
  assign advance   = seek & clk_en & ~use_xin & cur_hit & ~at_last;
  assign trig_fire = seek & clk_en & (use_xin ? xtrig_in : (cur_hit & at_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (restart) stage_q <= '0;
    else if (advance) stage_q <= stage_q + SW'(1);
  end

  // R3: the sequence moves forward one stage at a time
  a_r3_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (stage_q == $past(stage_q) || stage_q == $past(stage_q) + SW'(1)));

  // R4: every restart returns the sequence to stage 0
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> stage_q == '0);

  // R8: no stage progress without the sample enable
  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !restart) |=> $stable(stage_q));

endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int PW    = 8,
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  input  logic          busy,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_addr,
  output logic [PW-1:0] rd_data
);
  logic [PW-1:0] mem [DEPTH];
  logic [IW:0]   wptr;

  always_ff @(posedge clk) begin
    if (wr_en && !clear && wptr < (IW+1)'(DEPTH)) mem[wptr[IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wptr <= '0;
    else if (clear) wptr <= '0;
    else if (wr_en) wptr <= wptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rd_data <= '0;
    else if (rd_en && !busy)  rd_data <= mem[rd_addr];
  end

  // R6: windows never write past the buffer end
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |-> wptr < (IW+1)'(DEPTH));

  // R10: reads are ignored during a capture
  a_r10_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data));

endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
  parameter int PW     = 8,
  parameter int DEPTH  = 16,
  parameter int STAGES = 4,
  parameter int MAXWIN = 4,
  localparam int SW    = $clog2(STAGES),
  localparam int WSW   = $clog2(MAXWIN),
  localparam int AW    = $clog2(2 * STAGES + 3),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic [PW-1:0] probe,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [PW-1:0] cfg_wdata,
  input  logic          arm,
  input  logic          xtrig_in,
  output logic          xtrig_out,
  output logic          ready,
  output logic          done,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_addr,
  output logic [PW-1:0] rd_data
);
  import tcb_pkg::*;

  logic [STAGES-1:0][PW-1:0] stage_val, stage_msk;
  logic [PW-1:0]  qual_val, qual_msk;
  logic [SW-1:0]  stage_last;
  logic           use_xin;
  logic [WSW-1:0] win_last;

  cap_state_t     state;
  logic [WSW-1:0] win_idx;
  logic [IW:0]    fill;
  logic [IW:0]    win_len_w;
  logic           trig_fire, qual_hit, capturing, cap_wr;
  logic           win_full, last_win, seek, restart;

  tcb_cfg #(.PW(PW), .STAGES(STAGES), .AW(AW), .SW(SW), .WSW(WSW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .stage_val(stage_val), .stage_msk(stage_msk), .qual_val(qual_val),
    .qual_msk(qual_msk), .stage_last(stage_last), .use_xin(use_xin),
    .win_last(win_last)
  );

  tcb_trig #(.PW(PW), .STAGES(STAGES), .SW(SW)) u_trig (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .probe(probe), .seek(seek),
    .restart(restart), .stage_val(stage_val), .stage_msk(stage_msk),
    .stage_last(stage_last), .use_xin(use_xin), .xtrig_in(xtrig_in),
    .trig_fire(trig_fire)
  );

  tcb_store #(.PW(PW), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(arm), .wr_en(cap_wr), .wr_data(probe),
    .busy(ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign win_len_w = (IW+1)'(window_len(DEPTH, 32'(win_last) + 32'd1));
  assign qual_hit  = ~|((probe ^ qual_val) & qual_msk);
  assign capturing = ((state == ST_CAPT) & clk_en) | trig_fire;
  assign cap_wr    = capturing & qual_hit;
  assign win_full  = cap_wr & (fill == win_len_w - 1'b1);
  assign last_win  = (win_idx == win_last);
  assign seek      = (state == ST_WAIT);
  assign restart   = arm | win_full;
  assign ready     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_idx <= '0;
      fill    <= '0;
      done    <= 1'b0;
    end else if (arm) begin
      state   <= ST_WAIT;
      win_idx <= '0;
      fill    <= '0;
      done    <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (win_full) begin
        fill <= '0;
        if (last_win) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          state   <= ST_WAIT;
          win_idx <= win_idx + WSW'(1);
        end
      end else begin
        fill <= fill + (IW+1)'(cap_wr);
        if (trig_fire) state <= ST_CAPT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xtrig_out <= 1'b0;
    else        xtrig_out <= trig_fire;
  end

  // R1: a waiting core keeps its window empty
  a_r1_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !trig_fire && !arm) |=> fill == '0);

  // R7: every trigger produces an output pulse
  a_r7_xout_follows: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> xtrig_out);

  // R8: disabled samples change nothing
  a_r8_no_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !arm) |=> ($stable(state) && $stable(fill)));

  // R9: finished core is idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ready);

endmodule

// File: tb/trig_capture_buf_tb.sv
module trig_capture_buf_tb;
  logic       clk = 1'b0;
  logic       rst_n, clk_en, cfg_we, arm, xtrig_in, rd_en;
  logic [7:0] probe, cfg_wdata;
  logic [3:0] cfg_addr, rd_addr;
  logic       xtrig_out, ready, done;
  logic [7:0] rd_data;
  int         total = 0;
  int         bad = 0;
  logic [7:0] exp_mem [16];

  always #2.5 clk = ~clk;

  trig_capture_buf u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .probe(probe),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .arm(arm), .xtrig_in(xtrig_in), .xtrig_out(xtrig_out),
    .ready(ready), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic feed(input logic [7:0] v, input logic en);
    probe = v; clk_en = en;
    tick();
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_mem(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd(4'(i), d);
      check(d, exp_mem[i], tag);
    end
  endtask

  task automatic t_reset();
    check(ready, 0, "R9 ready after reset");
    check(done, 0, "R9 done after reset");
    check(xtrig_out, 0, "R7 xtrig_out after reset");
  endtask

  // Single stage, one window, qualifier open
  task automatic t_single();
    wcfg(4'd0, 8'hA5); wcfg(4'd4, 8'hFF); wcfg(4'd10, 8'h00);
    do_arm();
    check(ready, 1, "R1 ready after arm");
    feed(8'h01, 1); feed(8'h02, 1); feed(8'h03, 1);
    check(xtrig_out, 0, "R2 no trigger on mismatch");
    feed(8'hA5, 1);
    check(xtrig_out, 1, "R7 pulse after trigger");
    exp_mem[0] = 8'hA5;
    for (int i = 0; i < 15; i++) begin
      feed(8'h10 + 8'(i), 1);
      exp_mem[i+1] = 8'h10 + 8'(i);
      if (i == 0)  check(xtrig_out, 0, "R7 pulse lasts one cycle");
      if (i == 13) check(done, 0, "R9 done not early");
    end
    check(done, 1, "R9 done when full");
    check(ready, 0, "R9 ready low when done");
    check_mem(16, "R1 stored from trigger on");
  endtask

  // Three stages with masks, out-of-order patterns; re-arm and read block
  task automatic t_sequence();
    logic [7:0] d;
    wcfg(4'd0, 8'h11); wcfg(4'd4, 8'hFF);
    wcfg(4'd1, 8'h20); wcfg(4'd5, 8'hF0);
    wcfg(4'd2, 8'h03); wcfg(4'd6, 8'h0F);
    wcfg(4'd10, 8'h02);
    do_arm();
    check(done, 0, "R1 arm clears done");
    rd(4'd0, d);
    check(d, 8'h1E, "R10 read ignored while busy");
    feed(8'h2F, 1); feed(8'h03, 1); feed(8'h11, 1);
    feed(8'h03, 1); feed(8'h25, 1); feed(8'h11, 1);
    check(xtrig_out, 0, "R3 no trigger before last stage");
    feed(8'hF3, 1);
    check(xtrig_out, 1, "R3 trigger on last stage");
    exp_mem[0] = 8'hF3;
    for (int i = 0; i < 15; i++) begin
      feed(8'h40 + 8'(i), 1);
      exp_mem[i+1] = 8'h40 + 8'(i);
    end
    check(done, 1, "R3 sequence capture done");
    check_mem(16, "R2 masked sequence data");
  endtask

  // Re-arm in the middle of a sequence restarts at stage 0
  task automatic t_rearm();
    wcfg(4'd0, 8'h11); wcfg(4'd4, 8'hFF);
    wcfg(4'd1, 8'h22); wcfg(4'd5, 8'hFF);
    wcfg(4'd10, 8'h01);
    do_arm();
    feed(8'h11, 1);
    probe = 8'h00;
    do_arm();
    feed(8'h22, 1);
    check(xtrig_out, 0, "R4 re-arm restarts sequence");
    feed(8'h11, 1); feed(8'h22, 1);
    check(xtrig_out, 1, "R4 full sequence after re-arm");
    exp_mem[0] = 8'h22;
    for (int i = 0; i < 15; i++) begin
      feed(8'h60 + 8'(i), 1);
      exp_mem[i+1] = 8'h60 + 8'(i);
    end
    check(done, 1, "R4 done after re-arm run");
    check_mem(2, "R4 first samples");
  endtask

  // Two windows, odd-only qualifier, clock enable gaps
  task automatic t_qualify();
    int n;
    wcfg(4'd0, 8'h80); wcfg(4'd4, 8'h80);
    wcfg(4'd8, 8'h01); wcfg(4'd9, 8'h01);
    wcfg(4'd10, 8'h08);
    do_arm();
    feed(8'h81, 1);
    exp_mem[0] = 8'h81;
    n = 1;
    for (int v = 2; v <= 15; v++) begin
      if (v == 6) feed(8'h55, 0);
      feed(8'(v), 1);
      if (v % 2 == 1) begin exp_mem[n] = 8'(v); n++; end
    end
    check(done, 0, "R6 first window does not finish");
    check(ready, 1, "R6 waiting for second trigger");
    feed(8'h90, 0);
    check(xtrig_out, 0, "R8 no trigger with enable low");
    feed(8'h11, 1);
    feed(8'h90, 1);
    check(xtrig_out, 1, "R6 second window trigger");
    for (int i = 0; i < 16; i++) begin
      feed(8'h20 + 8'(i), 1);
      if (i % 2 == 1) begin exp_mem[n] = 8'h20 + 8'(i); n++; end
    end
    check(n, 16, "R5 expected list size");
    check(done, 1, "R6 done after second window");
    check_mem(16, "R5 qualified samples");
  endtask

  // External trigger source, three windows of five
  task automatic t_xtrig();
    wcfg(4'd0, 8'h00); wcfg(4'd4, 8'hFF);
    wcfg(4'd9, 8'h00);
    wcfg(4'd10, 8'h14);
    do_arm();
    xtrig_in = 1'b0;
    feed(8'h00, 1);
    check(xtrig_out, 0, "R7 probe stages ignored with external source");
    for (int w = 0; w < 3; w++) begin
      xtrig_in = 1'b1;
      feed(8'hA0 + 8'(w * 8), 1);
      xtrig_in = 1'b0;
      check(xtrig_out, 1, "R7 external trigger");
      exp_mem[w*5] = 8'hA0 + 8'(w * 8);
      for (int i = 1; i < 5; i++) begin
        feed(8'hA0 + 8'(w * 8 + i), 1);
        exp_mem[w*5+i] = 8'hA0 + 8'(w * 8 + i);
      end
      if (w < 2) check(done, 0, "R6 not done before last window");
    end
    check(done, 1, "R6 done after three windows");
    check_mem(15, "R6 three windows of floor(16/3)");
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; cfg_we = 1'b0; arm = 1'b0;
    xtrig_in = 1'b0; rd_en = 1'b0; probe = '0; cfg_wdata = '0;
    cfg_addr = '0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_sequence();
    t_rearm();
    t_qualify();
    t_xtrig();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule